// File: doc/BRIEF.md
# Serial-Loaded Multi-Channel DAC Code Bank

This block is the digital front end of a multi-channel 10-bit digital-to-analog converter. A host loads it over three wires: a shift clock, a serial data line and a load strobe. Each rising shift-clock edge pushes one bit into a 14-bit shift register. The host sends the most significant bit first. A complete word carries a 4-bit channel address in its upper bits and a 10-bit code in its lower bits. A rising edge on the load strobe passes the word through an address decoder. The decoder commits the code to exactly one channel register. The converters read those registers as parallel codes.

All three serial pins are asynchronous to the system clock. Each one is synchronized into the system clock domain, and its edges are detected there. An active-high asynchronous reset clears every channel code to zero, which drives every analog output low. The same reset also clears the shift register. The channel count is a parameter: the default is six channels, and a reduced build uses four.

Top module: `dac_regbank`

## Requirements
- R1: While `rst` is high, every channel code is zero. Reset also clears the shift register, so a load after fewer than 14 new bits sees zeros in the positions that have not been refilled.
- R2: Bits enter most significant first. After 14 shift-clock rises, the first four bits sent form the address (word bits 13:10) and the last ten form the code (word bits 9:0).
- R3: On a load-strobe rise, an address k with 1 <= k <= NUM_CH writes the code into channel k. Channel k occupies `ch_code[(k-1)*10 +: 10]`, and every other channel keeps its value.
- R4: A load-strobe rise with address 0, or with an address above NUM_CH, changes no channel.
- R5: Shift-clock activity while the load strobe stays low never changes any channel code.
- R6: Only the rising edge of the load strobe writes. Words shifted in while the strobe is held high are not committed until the next rise.
- R7: Reset acts asynchronously: the channel codes read zero before the next system clock edge after `rst` rises.
- R8: When more than 14 bits are shifted before a load, only the most recent 14 bits count.
- R9: With NUM_CH = 4, addresses 5 and 6 are ignored like any other out-of-range address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdata | input | 1 | Serial data, sampled on shift-clock rise |
| load | input | 1 | Load strobe, commits the word on its rising edge |
| ch_code | output | NUM_CH*10 | Channel codes, channel 1 in the least significant 10 bits |

## Verification
The case that is hardest to reach from the ports is a reset that lands on a partly filled shift register. If reset failed to clear the shift register, the bits left over could form a valid address. To expose this, the stimulus first shifts a word whose low nibble reads as address 1. It then resets, shifts only ten new bits and pulses load, and expects no channel to change. The held-strobe case is also reached on purpose: a whole word is shifted while load stays high, and nothing may change until the next rise.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 10;
    localparam int WORD_W = ADDR_W + DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } dac_word_t;
endpackage

// File: rtl/dac_sync_edge.sv
module dac_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.chain[STAGES-1];
    assign rise  = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/dac_shifter.sv
module dac_shifter
    import dac_regbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      shift_en,
    input  logic      bit_in,
    output dac_word_t word
);
    typedef struct packed {
        logic [WORD_W-1:0] bits;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[WORD_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word = dac_word_t'(st_q.bits);
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
    import dac_regbank_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  dac_word_t                word,
    output logic [NUM_CH*DATA_W-1:0] ch_code
);
    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] codes;
    } bank_t;

    bank_t             st_d, st_q;
    logic [NUM_CH-1:0] hit;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
        assign hit[k] = wr_en && (word.addr == ADDR_W'(k + 1));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_CH; k++) begin
            if (hit[k]) st_d.codes[k] = word.data;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ch_code = st_q.codes;
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     sdata,
    input  logic                     load,
    output logic [NUM_CH*DATA_W-1:0] ch_code
);
    localparam int N_PINS = 3;
    localparam int P_SCLK = 0;
    localparam int P_SDAT = 1;
    localparam int P_LOAD = 2;

    logic [N_PINS-1:0] pin_raw, pin_lvl, pin_rise;
    logic              load_rise;
    dac_word_t         shift_q;

    assign pin_raw = {load, sdata, sclk};

    for (genvar p = 0; p < N_PINS; p++) begin : g_sync
        dac_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (pin_raw[p]),
            .level    (pin_lvl[p]),
            .rise     (pin_rise[p])
        );
    end

    assign load_rise = pin_rise[P_LOAD];

    dac_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (pin_rise[P_SCLK]),
        .bit_in   (pin_lvl[P_SDAT]),
        .word     (shift_q)
    );

    dac_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_rise),
        .word    (shift_q),
        .ch_code (ch_code)
    );
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
    import dac_regbank_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     load_rise,
    input dac_word_t                shift_word,
    input logic [NUM_CH*DATA_W-1:0] ch_code
);
    logic [NUM_CH*DATA_W-1:0] prev_q;
    logic [NUM_CH-1:0]        chg;
    logic                     addr_ok;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev_q <= '0;
        else     prev_q <= ch_code;
    end

    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            chg[k] = (ch_code[k*DATA_W +: DATA_W] != prev_q[k*DATA_W +: DATA_W]);
        end
    end

    assign addr_ok = (shift_word.addr != '0) && (int'(shift_word.addr) <= NUM_CH);

    always @(posedge clk) begin
        if (rst) assert_reset_zero_R1: assert (ch_code == '0);
    end

    assert_single_channel_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg));

    assert_out_of_range_R4: assert property (@(posedge clk) disable iff (rst)
        (load_rise && !addr_ok) |=> $stable(ch_code));

    assert_no_load_no_change_R5: assert property (@(posedge clk) disable iff (rst)
        !load_rise |=> $stable(ch_code));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_wr
        assert_addressed_write_R3: assert property (@(posedge clk) disable iff (rst)
            (load_rise && shift_word.addr == ADDR_W'(k + 1))
            |=> ch_code[k*DATA_W +: DATA_W] == $past(shift_word.data));
    end
endmodule

bind dac_regbank dac_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_rise  (load_rise),
    .shift_word (shift_q),
    .ch_code    (ch_code)
);

// File: tb/dac_regbank_test.sv
module dac_regbank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        load = 1'b0;
    logic [59:0] ch6;
    logic [39:0] ch4;

    logic [9:0]  m6 [6];
    logic [9:0]  m4 [4];
    logic [13:0] sh;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_regbank #(.NUM_CH(6)) uut (
        .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .load(load), .ch_code(ch6));

    dac_regbank #(.NUM_CH(4)) uut4 (
        .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .load(load), .ch_code(ch4));

    task automatic model_clear();
        for (int k = 0; k < 6; k++) m6[k] = '0;
        for (int k = 0; k < 4; k++) m4[k] = '0;
        sh = '0;
    endtask

    task automatic model_load();
        int a;
        a = int'(sh[13:10]);
        if (a >= 1 && a <= 6) m6[a-1] = sh[9:0];
        if (a >= 1 && a <= 4) m4[a-1] = sh[9:0];
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < 6; k++) begin
            checks++;
            if (ch6[k*10 +: 10] !== m6[k]) begin
                errors++;
                $display("FAIL %s six-ch CH%0d actual %h expected %h", req, k+1, ch6[k*10 +: 10], m6[k]);
            end
        end
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (ch4[k*10 +: 10] !== m4[k]) begin
                errors++;
                $display("FAIL %s four-ch CH%0d actual %h expected %h", req, k+1, ch4[k*10 +: 10], m4[k]);
            end
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sdata = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        sh = {sh[12:0], b};
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [3:0] a, input logic [9:0] d);
        send_bits({18'd0, a, d}, 14);
    endtask

    task automatic pulse_load();
        @(negedge clk) load = 1'b1;
        model_load();
        repeat (6) @(negedge clk);
        load = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_0d1c));
        model_clear();
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2: MSB-first framing
        send_word(4'd3, 10'h2A5);
        pulse_load();
        check_all("R2 framing");

        // R3: every channel addressed in turn
        for (int k = 1; k <= 6; k++) begin
            send_word(4'(k), 10'(k * 97 + 5));
            pulse_load();
            check_all("R3 addressed write");
        end

        // R4 / R9: out-of-range addresses
        send_word(4'd0, 10'h3FF); pulse_load(); check_all("R4 addr 0");
        send_word(4'd7, 10'h111); pulse_load(); check_all("R4 addr 7");
        send_word(4'd15, 10'h222); pulse_load(); check_all("R4 addr 15");
        send_word(4'd5, 10'h0F0); pulse_load(); check_all("R9 addr 5 on four-ch");
        send_word(4'd6, 10'h00F); pulse_load(); check_all("R9 addr 6 on four-ch");

        // R5: shifting without load
        send_word(4'd2, 10'h155);
        check_all("R5 shift no load");

        // R6: held load strobe
        @(negedge clk) load = 1'b1;
        model_load();
        repeat (6) @(negedge clk);
        check_all("R6 rise writes");
        send_word(4'd1, 10'h0AA);
        check_all("R6 held no write");
        @(negedge clk) load = 1'b0;
        repeat (6) @(negedge clk);
        check_all("R6 fall no write");
        pulse_load();
        check_all("R6 next rise writes");

        // R8: extra leading bits discarded
        send_bits({13'h1ABC, 4'd4, 10'h321, 5'd0} >> 5, 27);
        pulse_load();
        check_all("R8 last 14 bits");

        // R7: asynchronous reset
        @(negedge clk);
        #1 rst = 1'b1;
        model_clear();
        #1 check_all("R7 async reset");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset clears the shift register
        send_word(4'd0, 10'h001);
        do_reset();
        send_bits(32'h155, 10);
        pulse_load();
        check_all("R1 shift cleared");

        // Random mix (R3 R4 R5 R9)
        for (int n = 0; n < 60; n++) begin
            logic [3:0] a;
            logic [9:0] d;
            a = 4'($urandom_range(0, 8));
            d = 10'($urandom);
            send_word(a, d);
            if ($urandom_range(0, 3) != 0) pulse_load();
            check_all("R3 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule